// File: doc/BRIEF.md
# Masked Dual-Rail Gate with Local Completion Enable

This block is a logic-level model of a single masked dual-rail gate. Each data input arrives as a rail pair that carries a bit already XORed with a random mask. The mask itself arrives the same way, as a rail pair. The gate evaluates AND, OR or XOR on the unmasked values and re-masks the result with the same mask bit. An elaboration parameter swaps the output rails, which turns the gate into NAND, NOR or XNOR without adding logic.

A local completion detector watches every input lane, including the mask. It keeps the output pair at the precharge code until all lanes carry a valid code. The output therefore makes at most one transition per evaluation phase. As soon as any lane returns to precharge, the output returns to precharge in the same evaluation. The inputs are synchronised this way, so non-monotonic functions such as XOR are legal. An XOR with an odd number of inputs needs no mask, because the masks cancel to a single mask. In that configuration the mask rails are ignored. A rail pair with both rails high is illegal: it raises an error flag and holds the output in precharge.

Top module: `dr_masked_gate`

## Requirements
- R1: Each rail pair is read as (true rail, false rail). (0,0) is precharge, (1,0) is logic 1, (0,1) is logic 0, and (1,1) is an illegal code.
- R2: While any data input pair is at precharge and no lane holds an illegal code, the output pair is (0,0) and the error flag is 0.
- R3: In configurations that use the mask, a mask pair at precharge holds the output pair at (0,0).
- R4: With the AND function and all lanes valid, the output's true rail equals AND(x_i XOR m) XOR m. Here x_i is the masked data bit and m is the mask bit. The false rail is its complement.
- R5: With the OR function and all lanes valid, the output's true rail equals OR(x_i XOR m) XOR m. The false rail is its complement.
- R6: With the XOR function and an even input count, the output's true rail equals XOR(x_i XOR m) XOR m. With an odd input count, it equals XOR(x_i), the mask rails have no effect on the outputs, and the mask is not waited for.
- R7: When the invert parameter is set, the two output rails are exchanged, so the gate gives the complemented function under the same mask.
- R8: An illegal (1,1) code on any data lane, or on the mask lane where the mask is used, drives the error flag to 1 and the output pair to (0,0).
- R9: The output pair never shows (1,1). Whenever every lane is valid, exactly one output rail is high.
- R10: After an evaluation, returning any single input lane to (0,0) brings the output back to (0,0) without any other input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_t | input | N_IN | True rails of the masked data inputs |
| in_f | input | N_IN | False rails of the masked data inputs |
| mask_t | input | 1 | True rail of the mask bit |
| mask_f | input | 1 | False rail of the mask bit |
| out_t | output | 1 | True rail of the masked result |
| out_f | output | 1 | False rail of the masked result |
| code_err | output | 1 | High while any watched lane carries the illegal code |

## Verification
The assertions assume that every lane holds one of the four two-bit codes, with no unknown values. They also assume that an input change is observed only after the combinational network has settled. The stimulus drives all rails to defined values at once, away from the clock edge, and samples one nanosecond later. It weights the random lane codes heavily toward valid values, so that fully evaluated cases dominate. Precharge and illegal codes still appear often enough to exercise the hold and error paths. Directed steps cover the first evaluation from an all-precharge start, a late mask, an ignored mask in odd XOR, and a single lane dropping back after evaluation.

// File: rtl/dr_gate_pkg.sv
package dr_gate_pkg;

  typedef enum logic [1:0] {
    GATE_AND = 2'd0,
    GATE_OR  = 2'd1,
    GATE_XOR = 2'd2
  } gate_fn_e;

  // An odd-width XOR keeps exactly one copy of the mask, so it needs none.
  function automatic bit mask_required(input gate_fn_e fn, input int n);
    return !(fn == GATE_XOR && (n % 2) == 1);
  endfunction

endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode (
  input  logic rail_t,
  input  logic rail_f,
  output logic lane_ok,
  output logic lane_bad,
  output logic lane_bit
);
  always_comb begin
    lane_ok  = rail_t ^ rail_f;
    lane_bad = rail_t & rail_f;
    lane_bit = rail_t;
  end
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int LANES = 3
) (
  input  logic [LANES-1:0] lane_ok,
  input  logic [LANES-1:0] lane_bad,
  output logic             eval_en,
  output logic             any_bad
);
  always_comb begin
    any_bad = |lane_bad;
    eval_en = (&lane_ok) & ~any_bad;
  end
endmodule

// File: rtl/dr_masked_core.sv
module dr_masked_core
  import dr_gate_pkg::*;
#(
  parameter int       N_IN = 2,
  parameter gate_fn_e FN   = GATE_AND
) (
  input  logic [N_IN-1:0] masked_bits,
  input  logic            mask_bit,
  output logic            q_masked
);
  logic [N_IN-1:0] plain;
  logic            g;

  assign plain = masked_bits ^ {N_IN{mask_bit}};

  generate
    if (FN == GATE_AND) begin : g_and
      assign g = &plain;
    end else if (FN == GATE_OR) begin : g_or
      assign g = |plain;
    end else begin : g_xor
      assign g = ^plain;
    end
  endgenerate

  assign q_masked = g ^ mask_bit;
endmodule

// File: rtl/dr_masked_gate.sv
module dr_masked_gate
  import dr_gate_pkg::*;
#(
  parameter int       N_IN   = 2,
  parameter gate_fn_e FN     = GATE_AND,
  parameter bit       INVERT = 1'b0
) (
  input  logic [N_IN-1:0] in_t,
  input  logic [N_IN-1:0] in_f,
  input  logic            mask_t,
  input  logic            mask_f,
  output logic            out_t,
  output logic            out_f,
  output logic            code_err
);
  localparam bit NEED_MASK = mask_required(FN, N_IN);
  localparam int LANES     = N_IN + (NEED_MASK ? 1 : 0);

  logic [LANES-1:0] lane_t, lane_f;
  logic [LANES-1:0] lane_ok, lane_bad, lane_bit;
  logic             m_bit;
  logic             eval_en;
  logic             q_masked;

  assign lane_t[N_IN-1:0] = in_t;
  assign lane_f[N_IN-1:0] = in_f;

  generate
    if (NEED_MASK) begin : g_mask
      assign lane_t[N_IN] = mask_t;
      assign lane_f[N_IN] = mask_f;
      assign m_bit        = lane_bit[N_IN];

      always_comb begin
        if (!(mask_t || mask_f)) begin
          assert_mask_pre_R3: assert (!out_t && !out_f)
            else $error("output left precharge while mask was precharged");
        end
        if (mask_t && mask_f) begin
          assert_mask_bad_R8: assert (code_err && !out_t && !out_f)
            else $error("illegal mask code not flagged");
        end
      end
    end else begin : g_nomask
      logic unused_mask;
      assign unused_mask = mask_t ^ mask_f;
      assign m_bit       = 1'b0;
    end
  endgenerate

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dr_rail_decode u_dec (
      .rail_t  (lane_t[i]),
      .rail_f  (lane_f[i]),
      .lane_ok (lane_ok[i]),
      .lane_bad(lane_bad[i]),
      .lane_bit(lane_bit[i])
    );
  end

  dr_completion #(.LANES(LANES)) u_done (
    .lane_ok (lane_ok),
    .lane_bad(lane_bad),
    .eval_en (eval_en),
    .any_bad (code_err)
  );

  dr_masked_core #(.N_IN(N_IN), .FN(FN)) u_core (
    .masked_bits(lane_bit[N_IN-1:0]),
    .mask_bit   (m_bit),
    .q_masked   (q_masked)
  );

  // Inversion is a rail exchange only.
  generate
    if (INVERT) begin : g_swap
      assign out_t = eval_en & ~q_masked;
      assign out_f = eval_en &  q_masked;
    end else begin : g_keep
      assign out_t = eval_en &  q_masked;
      assign out_f = eval_en & ~q_masked;
    end
  endgenerate

  always_comb begin
    assert_no_both_R9: assert (!(out_t && out_f))
      else $error("output pair shows illegal code");
    if (|(~in_t & ~in_f)) begin
      assert_data_pre_R2: assert (!out_t && !out_f)
        else $error("output evaluated with a precharged data lane");
    end
    if (|(in_t & in_f)) begin
      assert_data_bad_R8: assert (code_err && !out_t && !out_f)
        else $error("illegal data code not flagged");
    end
    if (!eval_en) begin
      assert_hold_pre_R10: assert (!out_t && !out_f)
        else $error("output moved before completion");
    end else begin
      assert_onehot_R9: assert (out_t ^ out_f)
        else $error("evaluated output not one-hot");
    end
  end
endmodule

// File: tb/tb_dr_masked_gate.sv
`timescale 1ns/1ps
module tb_dr_masked_gate;
  import dr_gate_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [2:0] in_t, in_f;
  logic       mask_t, mask_f;
  logic       a_t, a_f, a_e;
  logic       o_t, o_f, o_e;
  logic       x3_t, x3_f, x3_e;
  logic       x2_t, x2_f, x2_e;
  logic       n_t, n_f, n_e;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  dr_masked_gate #(.N_IN(3), .FN(GATE_AND), .INVERT(1'b0)) dut (
    .in_t(in_t), .in_f(in_f), .mask_t(mask_t), .mask_f(mask_f),
    .out_t(a_t), .out_f(a_f), .code_err(a_e));
  dr_masked_gate #(.N_IN(3), .FN(GATE_OR), .INVERT(1'b0)) dut_or (
    .in_t(in_t), .in_f(in_f), .mask_t(mask_t), .mask_f(mask_f),
    .out_t(o_t), .out_f(o_f), .code_err(o_e));
  dr_masked_gate #(.N_IN(3), .FN(GATE_XOR), .INVERT(1'b0)) dut_x3 (
    .in_t(in_t), .in_f(in_f), .mask_t(mask_t), .mask_f(mask_f),
    .out_t(x3_t), .out_f(x3_f), .code_err(x3_e));
  dr_masked_gate #(.N_IN(2), .FN(GATE_XOR), .INVERT(1'b0)) dut_x2 (
    .in_t(in_t[1:0]), .in_f(in_f[1:0]), .mask_t(mask_t), .mask_f(mask_f),
    .out_t(x2_t), .out_f(x2_f), .code_err(x2_e));
  dr_masked_gate #(.N_IN(3), .FN(GATE_AND), .INVERT(1'b1)) dut_nand (
    .in_t(in_t), .in_f(in_f), .mask_t(mask_t), .mask_f(mask_f),
    .out_t(n_t), .out_f(n_f), .code_err(n_e));

  // fn: 0 AND, 1 OR, 2 XOR. Returns {err, out_t, out_f}.
  function automatic logic [2:0] model(input int fn, input bit inv, input int n,
                                       input logic [2:0] t, input logic [2:0] f,
                                       input logic mt, input logic mf);
    bit use_m = !(fn == 2 && (n % 2) == 1);
    bit any_bad = 1'b0;
    bit all_ok  = 1'b1;
    logic m, g, q;
    for (int i = 0; i < n; i++) begin
      if (t[i] && f[i]) any_bad = 1'b1;
      if (t[i] == f[i]) all_ok = 1'b0;
    end
    if (use_m) begin
      if (mt && mf) any_bad = 1'b1;
      if (mt == mf) all_ok = 1'b0;
    end
    if (any_bad) return 3'b100;
    if (!all_ok) return 3'b000;
    m = use_m ? mt : 1'b0;
    g = (fn == 1) ? 1'b0 : ((fn == 0) ? 1'b1 : 1'b0);
    for (int i = 0; i < n; i++) begin
      if (fn == 0)      g = g & (t[i] ^ m);
      else if (fn == 1) g = g | (t[i] ^ m);
      else              g = g ^ (t[i] ^ m);
    end
    if (inv) g = ~g;
    q = g ^ m;
    return {1'b0, q, ~q};
  endfunction

  task automatic check(input string req, input string who,
                       input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got err/t/f=%b expected=%b (in_t=%b in_f=%b m=%b%b)",
               req, who, got, exp, in_t, in_f, mask_t, mask_f);
    end
  endtask

  task automatic check_all(input string req);
    check({req, "/R4"}, "and",  {a_e, a_t, a_f},    model(0, 0, 3, in_t, in_f, mask_t, mask_f));
    check({req, "/R5"}, "or",   {o_e, o_t, o_f},    model(1, 0, 3, in_t, in_f, mask_t, mask_f));
    check({req, "/R6"}, "xor3", {x3_e, x3_t, x3_f}, model(2, 0, 3, in_t, in_f, mask_t, mask_f));
    check({req, "/R6"}, "xor2", {x2_e, x2_t, x2_f}, model(2, 0, 2, in_t, in_f, mask_t, mask_f));
    check({req, "/R7"}, "nand", {n_e, n_t, n_f},    model(0, 1, 3, in_t, in_f, mask_t, mask_f));
  endtask

  task automatic drive(input logic [2:0] t, input logic [2:0] f,
                       input logic mt, input logic mf);
    @(negedge clk);
    in_t = t; in_f = f; mask_t = mt; mask_f = mf;
    #1;
  endtask

  function automatic logic [1:0] rand_code();
    int r = $urandom % 8;
    if (r == 0) return 2'b00;
    if (r == 1) return 2'b11;
    return ($urandom % 2) ? 2'b10 : 2'b01;
  endfunction

  initial begin
    logic [1:0] c;
    void'($urandom(32'd20240611));
    in_t = '0; in_f = '0; mask_t = 1'b0; mask_f = 1'b0;
    #1;
    // R1 R2: all lanes precharged
    check_all("R1_R2_idle");
    // First full evaluation, mask = 1, data 1,0,1
    drive(3'b101, 3'b010, 1'b1, 1'b0);
    check_all("R4_eval");
    drive(3'b111, 3'b000, 1'b0, 1'b1);
    check_all("R5_allones");
    drive(3'b000, 3'b111, 1'b1, 1'b0);
    check_all("R9_allzero");
    // R10: one lane returns to precharge
    drive(3'b001, 3'b110, 1'b0, 1'b1);
    check_all("R10_pre_eval");
    drive(3'b001, 3'b100, 1'b0, 1'b1);
    check_all("R10_drop");
    // R3: mask late; odd XOR still evaluates (R6)
    drive(3'b011, 3'b100, 1'b0, 1'b0);
    check_all("R3_mask_pre");
    // R6: illegal mask ignored by odd XOR, flagged elsewhere (R8)
    drive(3'b110, 3'b001, 1'b1, 1'b1);
    check_all("R8_mask_bad");
    // R8: illegal data lane plus a precharged lane
    drive(3'b100, 3'b101, 1'b1, 1'b0);
    check_all("R8_data_bad");
    drive(3'b010, 3'b101, 1'b0, 1'b1);
    check_all("R7_swap");
    // Constrained random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] t, f;
      for (int i = 0; i < 3; i++) begin
        c = rand_code();
        t[i] = c[1]; f[i] = c[0];
      end
      c = rand_code();
      drive(t, f, c[1], c[0]);
      check_all("R2_R8_rand");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule